// File: doc/BRIEF.md
# JTAG Test Clock Generator with Return-Clock Pacing

This block produces the test clock for a hardware JTAG master from a fast system clock. In divided mode the test clock is the system clock divided by a programmable even divisor, with equal high and low phases. In adaptive mode the block issues one test-clock edge at a time and holds off the next edge until the target echoes the current level on its returned clock. The returned clock passes through a two-stage synchroniser before it is compared.

If the echo does not arrive within a fixed budget of system clocks, the block forces the edge anyway, so the shift engine never stalls, and raises a sticky error flag. Software clears that flag with a strobe. This matters because asserting the JTAG reset line may stop the target's returned clock, and clearing the flag must not disturb the running clock. Along with the clock, the block emits one-cycle rise and fall enable pulses, which a shift engine running in the system clock domain uses to sample and launch data.

A new divisor or a new mode is staged and only becomes active at the next falling edge of the test clock. The high phase that is in progress therefore always completes at its original length.

Top module: `tckgen_top`

## Requirements
- R1: While rst_n is low at a clock edge, tck, tck_rise, tck_fall and rtck_err are 0 after that edge. The block leaves reset in divided mode with the divisor DIV_RST (default 4, giving 2 cycles high and 2 cycles low).
- R2: In divided mode with an even divisor D in the range 2..8190, tck stays high for exactly D/2 system clocks and low for exactly D/2 system clocks.
- R3: For an odd divisor D in the legal range, bit 0 of div_wdata is ignored, and each phase lasts (D-1)/2 system clocks.
- R4: A write with div_we high and div_wdata below 2 or above 8190 is ignored, and the previous divisor keeps setting the phase length.
- R5: A new divisor takes effect only from the next falling edge of tck. A high phase already in progress keeps its old length.
- R6: tck_rise is high for exactly the first system clock in which tck is 1 after being 0. tck_fall is high for exactly the first clock in which tck is 0 after being 1. Neither pulse occurs at any other time.
- R7: In adaptive mode, once rtck (after two synchroniser flops) equals tck, tck toggles at the next clock edge. With rtck looped straight back to tck, each phase lasts 3 system clocks.
- R8: In adaptive mode, if rtck has not matched for 1024 system clocks after an edge, tck is forced to toggle at the 1024th cycle and rtck_err goes to 1 in the same cycle. With rtck held at 0 this gives 1024 high and 1 low; with rtck held at 1 it gives 1 high and 1024 low.
- R9: rtck_err stays 1 until an err_clr strobe, and reads 0 on the clock after the strobe. The clear has no effect on tck timing.
- R10: An adapt_set strobe selects adaptive mode and an adapt_clr strobe selects divided mode. When both arrive in the same cycle, divided mode wins. The change applies only at the next falling edge of tck.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Divisor value, legal 2..DIV_MAX |
| adapt_set | input | 1 | Strobe: select adaptive mode |
| adapt_clr | input | 1 | Strobe: select divided mode |
| err_clr | input | 1 | Strobe: clear the sticky timeout flag |
| rtck | input | 1 | Returned clock from the target (asynchronous) |
| tck | output | 1 | Test clock to the target |
| tck_rise | output | 1 | One-cycle pulse in the first high cycle of tck |
| tck_fall | output | 1 | One-cycle pulse in the first low cycle of tck |
| rtck_err | output | 1 | Sticky returned-clock timeout flag |

## Verification
The bench writes a divisor in the middle of a long high phase and checks that this phase still runs to its old length while the following low phase uses the new one. A design that switched immediately would emit a truncated pulse. The bench also holds the returned clock stuck at each polarity and expects the exact asymmetric phases of 1024 and 1 cycles. An off-by-one timeout counter, or a design that waits forever, would show a different or missing edge. After a timeout it confirms that the flag survives the return of a healthy echo, and that clearing the flag leaves the 3-cycle echo pacing unchanged. Finally it sends illegal, odd and simultaneous set/clear writes. A design that accepted the illegal values, kept bit 0 of an odd divisor, or let set win over clear would show the wrong phase lengths.

// File: rtl/tckgen_pkg.sv
// Shared types and helpers for the test clock generator.
package tckgen_pkg;

    // Clock source selection for the generator.
    typedef enum logic {
        MODE_DIVIDED  = 1'b0,
        MODE_ADAPTIVE = 1'b1
    } tck_mode_e;

    // True when a divisor value lies inside the accepted range.
    function automatic logic div_ok(input logic [31:0] value, input int unsigned max_val);
        return (value >= 32'd2) && (value <= max_val);
    endfunction

endpackage

// File: rtl/tckgen_sync.sv
// Synchroniser chain for the asynchronous returned clock.
// Assumes STAGES >= 2; the output resets to 0, matching the reset level of tck.
module tckgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= d;
            end
        end else begin : g_next
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tckgen_divcnt.sv
// Phase counter for divided mode: asks for a tck toggle once the current
// phase has lasted `half` system clocks. Assumes half >= 1 and that the
// owner pulses `restart` on every toggle.
module tckgen_divcnt #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          restart,
    input  logic [HW-1:0] half,
    output logic          fire
);
    logic [HW-1:0] cnt;

    assign fire = en && (cnt == half - HW'(1));

    // Count cycles spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!en || restart) cnt <= '0;
        else                     cnt <= cnt + HW'(1);
    end
endmodule

// File: rtl/tckgen_adapt.sv
// Adaptive pacing: asks for a toggle once the synchronised returned clock
// matches tck, or forces the toggle after TMO cycles without a match.
// Assumes TMO >= 2.
module tckgen_adapt #(
    parameter int TMO = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tck,
    input  logic rtck_s,
    output logic fire,
    output logic tmo
);
    localparam int WW = $clog2(TMO);

    logic [WW-1:0] wcnt;
    logic          match;
    logic          limit;

    assign match = (rtck_s == tck);
    assign limit = (wcnt == WW'(TMO - 1));
    assign fire  = en && (match || limit);
    assign tmo   = en && !match && limit;

    // Count cycles spent waiting for the echo since the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n)           wcnt <= '0;
        else if (!en || fire) wcnt <= '0;
        else                  wcnt <= wcnt + WW'(1);
    end
endmodule

// File: rtl/tckgen_top.sv
// Test clock generator. It drives tck either from a programmable even divider
// or paced by the target's returned clock. Divisor and mode writes are staged
// and only applied at a falling edge of tck, so a phase is never cut short.
// Assumes rtck is asynchronous to clk.
module tckgen_top
    import tckgen_pkg::*;
#(
    parameter int DIV_W   = 13,
    parameter int DIV_MAX = 8190,
    parameter int DIV_RST = 4,
    parameter int TMO_CYC = 1024,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             adapt_set,
    input  logic             adapt_clr,
    input  logic             err_clr,
    input  logic             rtck,
    output logic             tck,
    output logic             tck_rise,
    output logic             tck_fall,
    output logic             rtck_err
);
    localparam int HW = DIV_W - 1;

    logic [HW-1:0] half_pend;
    logic [HW-1:0] half_act;
    tck_mode_e     mode_pend;
    tck_mode_e     mode_act;
    logic          adapt_act;
    logic          rtck_s;
    logic          div_fire;
    logic          ad_fire;
    logic          ad_tmo;
    logic          toggle;
    logic          div_legal;

    assign div_legal = div_ok(32'(div_wdata), DIV_MAX);
    assign adapt_act = (mode_act == MODE_ADAPTIVE);
    assign toggle    = adapt_act ? ad_fire : div_fire;

    // Stage a legal divisor as a half-period length.
    always_ff @(posedge clk) begin
        if (!rst_n)                     half_pend <= HW'(DIV_RST / 2);
        else if (div_we && div_legal)   half_pend <= div_wdata[DIV_W-1:1];
    end

    // Stage the mode; a clear strobe outranks a set strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_pend <= MODE_DIVIDED;
        else if (adapt_clr) mode_pend <= MODE_DIVIDED;
        else if (adapt_set) mode_pend <= MODE_ADAPTIVE;
    end

    // Apply the staged settings on a falling edge of tck.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_act <= HW'(DIV_RST / 2);
            mode_act <= MODE_DIVIDED;
        end else if (toggle && tck) begin
            half_act <= half_pend;
            mode_act <= mode_pend;
        end
    end

    // Drive tck and the edge enables from the selected toggle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck      <= 1'b0;
            tck_rise <= 1'b0;
            tck_fall <= 1'b0;
        end else begin
            tck      <= tck ^ toggle;
            tck_rise <= toggle && !tck;
            tck_fall <= toggle && tck;
        end
    end

    // Keep the timeout flag until software clears it; a new timeout wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       rtck_err <= 1'b0;
        else if (ad_tmo)  rtck_err <= 1'b1;
        else if (err_clr) rtck_err <= 1'b0;
    end

    tckgen_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rtck),
        .q     (rtck_s)
    );

    tckgen_divcnt #(.HW(HW)) u_divcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!adapt_act),
        .restart (toggle),
        .half    (half_act),
        .fire    (div_fire)
    );

    tckgen_adapt #(.TMO(TMO_CYC)) u_adapt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (adapt_act),
        .tck    (tck),
        .rtck_s (rtck_s),
        .fire   (ad_fire),
        .tmo    (ad_tmo)
    );
endmodule

// File: rtl/tckgen_chk.sv
// Property checker for tckgen_top, attached with bind. It tracks how long
// each tck level has lasted and relates that length to the settings in force.
module tckgen_chk #(
    parameter int HW      = 12,
    parameter int TMO_CYC = 1024
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tck,
    input logic          tck_rise,
    input logic          tck_fall,
    input logic          rtck_err,
    input logic          err_clr,
    input logic          adapt_act,
    input logic [HW-1:0] half_act
);
    localparam int TW = $clog2(TMO_CYC);
    localparam int CW = ((HW > TW) ? HW : TW) + 2;

    logic          tck_q;
    logic [CW-1:0] run_q;
    logic [HW-1:0] half_q;
    logic          adapt_q;
    logic          primed;

    // Record the previous level, the run length and the settings per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_q   <= 1'b0;
            run_q   <= '0;
            half_q  <= '0;
            adapt_q <= 1'b0;
            primed  <= 1'b0;
        end else begin
            tck_q   <= tck;
            run_q   <= (tck != tck_q) ? CW'(1) : run_q + CW'(1);
            half_q  <= half_act;
            adapt_q <= adapt_act;
            primed  <= 1'b1;
        end
    end

    p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tck != tck_q) && !adapt_q |-> run_q == CW'(half_q));

    p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tck != tck_q) && adapt_q |-> run_q <= CW'(TMO_CYC));

    p_rise_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tck_rise |-> tck && !tck_q);

    p_fall_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tck_fall |-> !tck && tck_q);

    p_edge_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tck != tck_q) |-> (tck_rise || tck_fall));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rtck_err && !err_clr |=> rtck_err);

    p_err_with_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtck_err) |-> tck != tck_q);

    p_mode_at_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        primed && (adapt_act != adapt_q) |-> tck_fall);

    p_half_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        primed && (half_act != half_q) |-> tck_fall);
endmodule

bind tckgen_top tckgen_chk #(.HW(DIV_W - 1), .TMO_CYC(TMO_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tck       (tck),
    .tck_rise  (tck_rise),
    .tck_fall  (tck_fall),
    .rtck_err  (rtck_err),
    .err_clr   (err_clr),
    .adapt_act (adapt_act),
    .half_act  (half_act)
);

// File: tb/tckgen_top_test.sv
module tckgen_top_test;
    localparam int DW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          div_we = 1'b0;
    logic [DW-1:0] div_wdata = '0;
    logic          adapt_set = 1'b0;
    logic          adapt_clr = 1'b0;
    logic          err_clr = 1'b0;
    logic          stuck_en = 1'b0;
    logic          stuck_val = 1'b0;
    logic          rtck;
    logic          tck, tck_rise, tck_fall, rtck_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int edge_bad = 0;
    int rises = 0;

    // Each row: divisor, expected high cycles, expected low cycles.
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{2, 1, 1}, '{4, 2, 2}, '{10, 5, 5},
        '{7, 3, 3}, '{64, 32, 32}, '{8190, 4095, 4095}
    };

    always #2.5 clk = ~clk;

    assign rtck = stuck_en ? stuck_val : tck;

    tckgen_top uut (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
        .adapt_set(adapt_set), .adapt_clr(adapt_clr), .err_clr(err_clr),
        .rtck(rtck), .tck(tck), .tck_rise(tck_rise), .tck_fall(tck_fall),
        .rtck_err(rtck_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic measure(output int hi, output int lo);
        @(negedge clk);
        while (tck !== 1'b0) @(negedge clk);
        while (tck !== 1'b1) @(negedge clk);
        hi = 0;
        while (tck === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (tck === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic write_div(input int v);
        @(negedge clk);
        div_wdata = DW'(v);
        div_we = 1'b1;
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic strobe(input bit s, input bit c, input bit e);
        @(negedge clk);
        adapt_set = s; adapt_clr = c; err_clr = e;
        @(negedge clk);
        adapt_set = 1'b0; adapt_clr = 1'b0; err_clr = 1'b0;
    endtask

    // R6 monitor: pulses must mark exactly the first cycle of each level.
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tck_rise !== (tck && !prev)) edge_bad++;
                if (tck_fall !== (!tck && prev)) edge_bad++;
                if (tck_rise === 1'b1) rises++;
            end
            prev = tck;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, lo;
        repeat (4) @(negedge clk);
        chk("R1", "tck in reset", int'(tck), 0);
        chk("R1", "tck_rise in reset", int'(tck_rise), 0);
        chk("R1", "tck_fall in reset", int'(tck_fall), 0);
        chk("R1", "rtck_err in reset", int'(rtck_err), 0);
        rst_n = 1'b1;
        measure(hi, lo);
        chk("R1", "default high", hi, 2);
        chk("R1", "default low", lo, 2);

        // Divided-mode table (R2 even, R3 odd).
        for (int i = 0; i < NV; i++) begin
            write_div(VEC[i][0]);
            measure(hi, lo);
            measure(hi, lo);
            chk((VEC[i][0] % 2 == 1) ? "R3" : "R2", "high", hi, VEC[i][1]);
            chk((VEC[i][0] % 2 == 1) ? "R3" : "R2", "low", lo, VEC[i][2]);
        end

        // R4: out-of-range writes leave the divisor unchanged.
        write_div(10);
        measure(hi, lo);
        write_div(0);
        write_div(1);
        write_div(8191);
        measure(hi, lo);
        measure(hi, lo);
        chk("R4", "high after illegal writes", hi, 5);
        chk("R4", "low after illegal writes", lo, 5);

        // R5: a write during a high phase does not shorten it.
        write_div(20);
        measure(hi, lo);
        @(negedge clk);
        while (tck !== 1'b0) @(negedge clk);
        while (tck !== 1'b1) @(negedge clk);
        hi = 1;
        div_wdata = DW'(4);
        div_we = 1'b1;
        @(negedge clk);
        div_we = 1'b0;
        while (tck === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (tck === 1'b0) begin lo++; @(negedge clk); end
        chk("R5", "high phase keeps old length", hi, 10);
        chk("R5", "low phase uses new length", lo, 2);
        measure(hi, lo);
        chk("R5", "next high uses new length", hi, 2);

        // R7: adaptive mode with a direct loopback.
        strobe(1'b1, 1'b0, 1'b0);
        measure(hi, lo);
        measure(hi, lo);
        chk("R7", "loopback high", hi, 3);
        chk("R7", "loopback low", lo, 3);
        chk("R7", "no error with echo", int'(rtck_err), 0);

        // R8: returned clock stuck low, then stuck high.
        stuck_en = 1'b1;
        stuck_val = 1'b0;
        measure(hi, lo);
        measure(hi, lo);
        chk("R8", "stuck-low high", hi, 1024);
        chk("R8", "stuck-low low", lo, 1);
        chk("R8", "timeout flag", int'(rtck_err), 1);
        stuck_val = 1'b1;
        measure(hi, lo);
        measure(hi, lo);
        chk("R8", "stuck-high high", hi, 1);
        chk("R8", "stuck-high low", lo, 1024);

        // R9: flag is sticky and clearing it leaves pacing alone.
        stuck_en = 1'b0;
        measure(hi, lo);
        measure(hi, lo);
        chk("R9", "flag held after echo returns", int'(rtck_err), 1);
        strobe(1'b0, 1'b0, 1'b1);
        chk("R9", "flag after clear", int'(rtck_err), 0);
        measure(hi, lo);
        chk("R9", "high after clear", hi, 3);
        chk("R9", "low after clear", lo, 3);

        // R10: simultaneous set and clear selects divided mode.
        strobe(1'b1, 1'b1, 1'b0);
        measure(hi, lo);
        measure(hi, lo);
        chk("R10", "divided high after set+clear", hi, 2);
        chk("R10", "divided low after set+clear", lo, 2);
        strobe(1'b1, 1'b1, 1'b0);
        measure(hi, lo);
        chk("R10", "stays divided", hi, 2);

        // R6: edge pulses seen by the monitor.
        chk("R6", "misplaced edge pulses", edge_bad, 0);
        chk("R6", "rise pulses observed", int'(rises > 0), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule